// File: doc/BRIEF.md
# Buffered Angle Update Scheduler

This block is the register front end that software uses to move the pointer of one of several PWM coil-driver units to a new angle. A new angle is described by three values: a selection word (target unit and quadrant), a cosine compare value and a sine compare value. Software writes them into holding registers in that order: selection first, cosine next, sine last. Writing the sine value arms a scheduled transfer and raises a busy flag.

The transfer copies all three held values into the working registers of the selected unit on a single clock edge. That edge is the first one at which the PWM counter reports a wrap to zero, so a new compare set always starts at the beginning of a PWM period and a unit never runs with a mix of old and new values. The busy flag drops on the same edge. Software polls it to learn that the download is finished. While busy is high, further writes are refused and a one-cycle reject flag reports this. The PWM waveform generation and the rotor blockage sensing sit outside this block.

Top module: `angleUpdSched`

## Requirements
- R1: After reset every unit's sine, cosine and quadrant working registers are zero, and busy and wrReject are low.
- R2: A write goes to the register selected by wrAddr: 0 is the selection word (unit number in bits [2:0], quadrant in bits [4:3], bits [7:5] reserved), 1 is cosine and 2 is sine. A write to address 3 has no effect, and busy stays low.
- R3: An accepted write to the sine address raises busy in the cycle after the write.
- R4: When busy is high and periodStart is high at a clock edge, the held sine, cosine and quadrant appear together at the selected unit's outputs after that edge, and busy is low after the same edge.
- R5: Working registers change only at the commit edge of R4. While busy stays high without periodStart, all working registers keep their values.
- R6: A write made while busy is high changes no holding register. wrReject is high for exactly the one cycle that follows such a write and is low at all other times.
- R7: If the held unit number is not below NUM_UNITS, or any reserved selection bit is set, the commit edge changes no working register, but busy still clears.
- R8: A commit changes only the selected unit. All other units keep their working values.
- R9: A sine write made in the same cycle as periodStart does not commit on that edge. Its transfer waits for the next periodStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Holding register address (0 select, 1 cosine, 2 sine) |
| wrData | input | DATA_W | Write data |
| periodStart | input | 1 | PWM counter wrap-to-zero strobe |
| busy | output | 1 | Transfer pending |
| wrReject | output | 1 | Previous-cycle write was refused because busy was high |
| unitSin | output | NUM_UNITS*DATA_W | Sine working registers, unit u at [u*DATA_W +: DATA_W] |
| unitCos | output | NUM_UNITS*DATA_W | Cosine working registers, same packing |
| unitQuad | output | NUM_UNITS*2 | Quadrant working registers, unit u at [u*2 +: 2] |

## Verification
Every result of this block is registered once, so each one is due exactly one edge after the stimulus that causes it:
- busy rises one edge after the sine write.
- wrReject pulses one edge after a refused write.
- The working values and the falling busy appear one edge after a cycle in which busy and periodStart were both high.

The bench drives inputs on the falling clock edge. A behavioural model updates on the rising edge from the same inputs. All outputs are compared at the next falling edge, so every comparison falls in the cycle where a result first becomes due. Directed checks name the requirement behind each scenario, including the case where the sine write coincides with periodStart.

// File: rtl/angleUpdSched_pkg.sv
package angleUpdSched_pkg;
  localparam logic [1:0] ADDR_SEL = 2'd0;
  localparam logic [1:0] ADDR_COS = 2'd1;
  localparam logic [1:0] ADDR_SIN = 2'd2;

  typedef struct packed {
    logic loadSel;
    logic loadCos;
    logic loadSin;
    logic commit;
  } schedStrobe_t;
endpackage

// File: rtl/angleUpdSched_ctrl.sv
module angleUpdSched_ctrl
  import angleUpdSched_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 8,
  parameter int UNIT_W    = 3,
  parameter int QUAD_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] holdSel,
  input  logic              periodStart,
  output schedStrobe_t      strobe,
  output logic              busy,
  output logic              wrReject
);
  localparam int RSVD_LO = UNIT_W + QUAD_W;

  logic busyQ, rejectQ, accept, selValid;

  assign accept   = wrEn && !busyQ;
  assign selValid = ({1'b0, holdSel[UNIT_W-1:0]} < (UNIT_W+1)'(NUM_UNITS))
                    && (holdSel[DATA_W-1:RSVD_LO] == '0);

  always_comb begin
    strobe.loadSel = accept && (wrAddr == ADDR_SEL);
    strobe.loadCos = accept && (wrAddr == ADDR_COS);
    strobe.loadSin = accept && (wrAddr == ADDR_SIN);
    strobe.commit  = busyQ && periodStart && selValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      rejectQ <= 1'b0;
    end else begin
      rejectQ <= wrEn && busyQ;
      if (busyQ && periodStart) busyQ <= 1'b0;
      else if (strobe.loadSin)  busyQ <= 1'b1;
    end
  end

  assign busy     = busyQ;
  assign wrReject = rejectQ;
endmodule

// File: rtl/angleUpdSched_dp.sv
module angleUpdSched_dp
  import angleUpdSched_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 8,
  parameter int UNIT_W    = 3,
  parameter int QUAD_W    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DATA_W-1:0]             wrData,
  input  schedStrobe_t                  strobe,
  output logic [DATA_W-1:0]             holdSel,
  output logic [NUM_UNITS*DATA_W-1:0]   unitSin,
  output logic [NUM_UNITS*DATA_W-1:0]   unitCos,
  output logic [NUM_UNITS*QUAD_W-1:0]   unitQuad
);
  logic [DATA_W-1:0] selQ, cosQ, sinQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      cosQ <= '0;
      sinQ <= '0;
    end else begin
      if (strobe.loadSel) selQ <= wrData;
      if (strobe.loadCos) cosQ <= wrData;
      if (strobe.loadSin) sinQ <= wrData;
    end
  end

  assign holdSel = selQ;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
    logic hit;
    assign hit = strobe.commit && (selQ[UNIT_W-1:0] == UNIT_W'(u));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        unitSin[u*DATA_W +: DATA_W]  <= '0;
        unitCos[u*DATA_W +: DATA_W]  <= '0;
        unitQuad[u*QUAD_W +: QUAD_W] <= '0;
      end else if (hit) begin
        unitSin[u*DATA_W +: DATA_W]  <= sinQ;
        unitCos[u*DATA_W +: DATA_W]  <= cosQ;
        unitQuad[u*QUAD_W +: QUAD_W] <= selQ[UNIT_W +: QUAD_W];
      end
    end
  end
endmodule

// File: rtl/angleUpdSched.sv
module angleUpdSched
  import angleUpdSched_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [1:0]                    wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          periodStart,
  output logic                          busy,
  output logic                          wrReject,
  output logic [NUM_UNITS*DATA_W-1:0]   unitSin,
  output logic [NUM_UNITS*DATA_W-1:0]   unitCos,
  output logic [NUM_UNITS*2-1:0]        unitQuad
);
  localparam int UNIT_W = 3;
  localparam int QUAD_W = 2;

  schedStrobe_t      strobe;
  logic [DATA_W-1:0] holdSel;

  angleUpdSched_ctrl #(.NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W),
                       .UNIT_W(UNIT_W), .QUAD_W(QUAD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .holdSel(holdSel), .periodStart(periodStart),
    .strobe(strobe), .busy(busy), .wrReject(wrReject)
  );

  angleUpdSched_dp #(.NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W),
                     .UNIT_W(UNIT_W), .QUAD_W(QUAD_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobe(strobe),
    .holdSel(holdSel), .unitSin(unitSin), .unitCos(unitCos),
    .unitQuad(unitQuad)
  );
endmodule

// File: rtl/angleUpdSched_chk.sv
module angleUpdSched_chk #(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        wrEn,
  input logic [1:0]                  wrAddr,
  input logic                        periodStart,
  input logic                        busy,
  input logic                        wrReject,
  input logic [NUM_UNITS*DATA_W-1:0] unitSin,
  input logic [NUM_UNITS*DATA_W-1:0] unitCos,
  input logic [NUM_UNITS*2-1:0]      unitQuad
);
  a_r3_sine_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && wrAddr == 2'd2 && !periodStart) |=> busy);

  a_r4_busy_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busy && periodStart) |=> !busy);

  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !periodStart) |=> busy);

  a_r5_work_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && periodStart) |=> ($stable(unitSin) && $stable(unitCos) && $stable(unitQuad)));

  a_r6_reject_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> wrReject);

  a_r6_no_spurious_reject: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && busy) |=> !wrReject);

  a_r2_addr3_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn && wrAddr == 2'd3) |=> !busy);
endmodule

bind angleUpdSched angleUpdSched_chk #(.NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .periodStart(periodStart),
  .busy(busy), .wrReject(wrReject), .unitSin(unitSin), .unitCos(unitCos),
  .unitQuad(unitQuad)
);

// File: tb/angleUpdSched_tb.sv
module angleUpdSched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic periodStart = 1'b0;
  logic busy, wrReject;
  logic [N*DW-1:0] unitSin, unitCos;
  logic [N*2-1:0] unitQuad;

  int vecCount = 0;
  int errCount = 0;
  int cycles = 0;

  // Behavioural reference model
  int mSin[N], mCos[N], mQuad[N];
  int hSel = 0, hCos = 0, hSin = 0;
  bit mBusy = 0, mRej = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  angleUpdSched #(.NUM_UNITS(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .periodStart(periodStart), .busy(busy), .wrReject(wrReject),
    .unitSin(unitSin), .unitCos(unitCos), .unitQuad(unitQuad)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      for (int u = 0; u < N; u++) begin
        mSin[u] <= 0; mCos[u] <= 0; mQuad[u] <= 0;
      end
      hSel <= 0; hCos <= 0; hSin <= 0; mBusy <= 0; mRej <= 0;
    end else begin
      mRej <= wrEn && mBusy;
      if (mBusy && periodStart) begin
        mBusy <= 0;
        if ((hSel % 8) < N && (hSel / 32) == 0) begin
          mSin[hSel % 8]  <= hSin;
          mCos[hSel % 8]  <= hCos;
          mQuad[hSel % 8] <= (hSel / 8) % 4;
        end
      end else if (wrEn && wrAddr == 2 && !mBusy) begin
        mBusy <= 1;
      end
      if (wrEn && !mBusy) begin
        if (wrAddr == 0) hSel <= int'(wrData);
        else if (wrAddr == 1) hCos <= int'(wrData);
        else if (wrAddr == 2) hSin <= int'(wrData);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check("R3 busy", int'(busy), int'(mBusy));
      check("R6 wrReject", int'(wrReject), int'(mRej));
      for (int u = 0; u < N; u++) begin
        check("R5 sin", int'(unitSin[u*DW +: DW]), mSin[u]);
        check("R5 cos", int'(unitCos[u*DW +: DW]), mCos[u]);
        check("R5 quad", int'(unitQuad[u*2 +: 2]), mQuad[u]);
      end
    end
  end

  task automatic step(input bit we, input int addr, input int data, input bit ps);
    wrEn = we; wrAddr = 2'(addr); wrData = DW'(data); periodStart = ps;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; periodStart = 1'b0;
  endtask

  task automatic loadAngle(input int sel, input int c, input int s);
    step(1, 0, sel, 0);
    step(1, 1, c, 0);
    step(1, 2, s, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 reject", int'(wrReject), 0);
    check("R1 sin", int'(unitSin), 0);
    check("R1 quad", int'(unitQuad), 0);

    // R3, R4, R8: unit 1 quadrant 2
    loadAngle(8'h11, 8'h40, 8'h80);
    check("R3 busy after sine", int'(busy), 1);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    check("R5 held while busy", int'(unitSin[1*DW +: DW]), 0);
    step(0, 0, 0, 1);
    check("R4 sin", int'(unitSin[1*DW +: DW]), 8'h80);
    check("R4 cos", int'(unitCos[1*DW +: DW]), 8'h40);
    check("R4 quad", int'(unitQuad[2 +: 2]), 2);
    check("R4 busy clear", int'(busy), 0);
    check("R8 unit0", int'(unitSin[0 +: DW]), 0);

    // R6: writes while busy refused
    loadAngle(8'h1A, 8'h22, 8'h33);
    step(1, 2, 8'hEE, 0);
    check("R6 reject", int'(wrReject), 1);
    step(1, 1, 8'hDD, 0);
    check("R6 reject again", int'(wrReject), 1);
    step(0, 0, 0, 0);
    check("R6 reject one cycle", int'(wrReject), 0);
    step(0, 0, 0, 1);
    check("R6 sin kept", int'(unitSin[2*DW +: DW]), 8'h33);
    check("R6 cos kept", int'(unitCos[2*DW +: DW]), 8'h22);
    check("R6 quad", int'(unitQuad[2*2 +: 2]), 3);

    // R7: out-of-range unit and reserved bit
    loadAngle(8'h05, 8'h77, 8'h66);
    step(0, 0, 0, 1);
    check("R7 busy cleared", int'(busy), 0);
    check("R7 no change", int'(unitSin[3*DW +: DW]), 0);
    loadAngle(8'h21, 8'h01, 8'h02);
    step(0, 0, 0, 1);
    check("R7 reserved bit", int'(unitSin[1*DW +: DW]), 8'h80);

    // R9: sine write coincides with periodStart
    step(1, 0, 8'h08, 0);
    step(1, 1, 8'h55, 0);
    step(1, 2, 8'hAA, 1);
    check("R9 busy", int'(busy), 1);
    check("R9 not yet", int'(unitSin[0 +: DW]), 0);
    step(0, 0, 0, 1);
    check("R9 committed", int'(unitSin[0 +: DW]), 8'hAA);
    check("R9 quad", int'(unitQuad[0 +: 2]), 1);

    // R2: address 3 ignored
    step(1, 3, 8'hFF, 0);
    check("R2 addr3 no busy", int'(busy), 0);
    step(0, 0, 0, 1);
    check("R2 addr3 no change", int'(unitSin[0 +: DW]), 8'hAA);

    // Sweep all units and quadrants
    for (int u = 0; u < N; u++) begin
      loadAngle(u + 8 * ((u + 1) % 4), 16 * u + 3, 200 - u);
      step(0, 0, 0, 0);
      step(0, 0, 0, 1);
      check("R8 sweep sin", int'(unitSin[u*DW +: DW]), 200 - u);
      check("R8 sweep quad", int'(unitQuad[u*2 +: 2]), (u + 1) % 4);
    end

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errCount++;
    $display("FAIL watchdog: actual %0d expected 0", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule